// File: doc/BRIEF.md
# Linear-Step Frequency Ramp Generator

This block produces the tuning word that feeds a phase accumulator. It does not jump between a low word and a high word. It walks from one to the other in equal increments. A 48-bit frequency register moves by a fixed magnitude each time a programmable interval timer runs out. A direction input picks the endpoint to approach. When the register would step past that endpoint, it lands on the endpoint exactly and stays there.

A freeze input stops the register and the interval timer together. When the freeze is released, the sweep continues with its step spacing intact. The low bound, high bound, step magnitude and interval length are plain register inputs that surrounding control logic holds steady. The tuning word is a plain registered level that the consumer reads every cycle. There is no handshake and no back-pressure, because a phase accumulator takes a new word on every clock.

Top module: `fsk_ramp_sweep`

## Requirements
- R1: While `rst` is high, `tune_word` is loaded with `lo_word` on each clock. The interval counter is loaded with `step_interval` at the same time.
- R2: When not frozen, the interval counter counts down by one per clock. On the clock where it is zero, one step is taken and the counter reloads `step_interval`. With the counter just loaded, steps therefore occur every `step_interval`+1 clocks.
- R3: On a step with `dir_up`=1, `tune_word` increases by `step_mag` when the result stays below `hi_word`.
- R4: On a step with `dir_up`=0, `tune_word` decreases by `step_mag` when the result stays above `lo_word`.
- R5: On an upward step whose sum would reach or pass `hi_word`, `tune_word` becomes exactly `hi_word`. It remains there while `dir_up` stays 1.
- R6: On a downward step that would reach or pass `lo_word`, `tune_word` becomes exactly `lo_word`. It remains there while `dir_up` stays 0.
- R7: While `freeze` is 1, neither `tune_word` nor the interval counter changes. After release, the next step comes after the remaining count, not after a fresh interval.
- R8: `tune_word` changes only on clocks where a step is taken or `rst` is high.
- R9: Upward steps near the top of the 48-bit range clamp to `hi_word` and never wrap to a small value. Downward steps near zero clamp to `lo_word` and never wrap to a large value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_word | input | 48 | Lower endpoint tuning word (must not exceed `hi_word`) |
| hi_word | input | 48 | Upper endpoint tuning word |
| step_mag | input | 48 | Step magnitude, a positive value |
| step_interval | input | 20 | Interval counter reload value |
| dir_up | input | 1 | 1 ramps toward `hi_word`, 0 ramps toward `lo_word` |
| freeze | input | 1 | 1 halts the sweep and the interval counter |
| tune_word | output | 48 | Instantaneous tuning word |

## Verification
A fault in the interval counter shows up at the port as a step that arrives a clock early or late. A cycle-by-cycle comparison therefore catches it at the first step after reset or after a release of `freeze`. A fault in the clamp shows up as a word one step past an endpoint, or as a wrapped value. That is visible on the very clock the endpoint is reached, so the stimulus places endpoints both on and off the step grid and near the top of the word range. A counter that keeps running while the register is frozen moves the first step after release. The freeze test places its release part-way through an interval to expose this.

// File: rtl/fsk_ramp_pkg.sv
package fsk_ramp_pkg;
  localparam int unsigned FREQ_W_DEF = 48;
  localparam int unsigned RATE_W_DEF = 20;

  typedef enum logic {
    RAMP_DOWN = 1'b0,
    RAMP_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/fsk_rate_timer.sv
module fsk_rate_timer #(
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic [RATE_W-1:0] reload,
  output logic              step
);
  logic [RATE_W-1:0] cnt_q;

  assign step = (cnt_q == '0) && !freeze;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= reload;
    else if (step)   cnt_q <= reload;
    else if (!freeze) cnt_q <= cnt_q - 1'b1;
  end

  // R2: a step reloads the counter
  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == $past(reload)));
  // R7: counter frozen while freeze is high
  a_r7_timer_frozen: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(cnt_q));
endmodule

// File: rtl/fsk_step_calc.sv
module fsk_step_calc
  import fsk_ramp_pkg::*;
#(
  parameter int unsigned FREQ_W = 48
) (
  input  logic [FREQ_W-1:0] cur,
  input  logic [FREQ_W-1:0] lo_bound,
  input  logic [FREQ_W-1:0] hi_bound,
  input  logic [FREQ_W-1:0] mag,
  input  ramp_dir_e         dir,
  output logic [FREQ_W-1:0] nxt
);
  localparam int unsigned XW = FREQ_W + 1;

  logic [XW-1:0] up_sum;
  logic [XW-1:0] down_limit;

  always_comb begin
    up_sum     = {1'b0, cur} + {1'b0, mag};
    down_limit = {1'b0, lo_bound} + {1'b0, mag};
    if (dir == RAMP_UP) begin
      nxt = (up_sum >= {1'b0, hi_bound}) ? hi_bound : up_sum[FREQ_W-1:0];
    end else begin
      nxt = ({1'b0, cur} <= down_limit) ? lo_bound : (cur - mag);
    end
  end
endmodule

// File: rtl/fsk_ramp_sweep.sv
module fsk_ramp_sweep
  import fsk_ramp_pkg::*;
#(
  parameter int unsigned FREQ_W = FREQ_W_DEF,
  parameter int unsigned RATE_W = RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] lo_word,
  input  logic [FREQ_W-1:0] hi_word,
  input  logic [FREQ_W-1:0] step_mag,
  input  logic [RATE_W-1:0] step_interval,
  input  logic              dir_up,
  input  logic              freeze,
  output logic [FREQ_W-1:0] tune_word
);
  logic              step;
  logic [FREQ_W-1:0] next_word;
  logic [FREQ_W-1:0] acc_q;
  ramp_dir_e         dir;

  assign dir = dir_up ? RAMP_UP : RAMP_DOWN;

  fsk_rate_timer #(.RATE_W(RATE_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .freeze (freeze),
    .reload (step_interval),
    .step   (step)
  );

  fsk_step_calc #(.FREQ_W(FREQ_W)) calc_i (
    .cur      (acc_q),
    .lo_bound (lo_word),
    .hi_bound (hi_word),
    .mag      (step_mag),
    .dir      (dir),
    .nxt      (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= lo_word;
    else if (step) acc_q <= next_word;
  end

  assign tune_word = acc_q;

  // R3: upward ramp never decreases while at or below the top
  a_r3_up_monotonic: assert property (@(posedge clk) disable iff (rst)
    (dir_up && acc_q <= hi_word) |=> (acc_q >= $past(acc_q)));
  // R5: upward ramp never passes the upper endpoint
  a_r5_no_overshoot: assert property (@(posedge clk) disable iff (rst)
    (dir_up && acc_q <= hi_word) |=> (acc_q <= $past(hi_word)));
  // R6: downward ramp never passes the lower endpoint
  a_r6_no_undershoot: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && acc_q >= lo_word) |=> (acc_q >= $past(lo_word)));
  // R7: word frozen while freeze is high
  a_r7_word_frozen: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(acc_q));
  // R8: word moves only on a step
  a_r8_change_on_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));
endmodule

// File: tb/fsk_ramp_sweep_tb_top.sv
module fsk_ramp_sweep_tb_top;
  localparam int FW = 48;
  localparam int RW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [FW-1:0] lo_word = 48'd1000;
  logic [FW-1:0] hi_word = 48'd1100;
  logic [FW-1:0] step_mag = 48'd30;
  logic [RW-1:0] step_interval = 20'd3;
  logic          dir_up = 1'b0;
  logic          freeze = 1'b0;
  logic [FW-1:0] tune_word;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  longint unsigned m_word;
  longint unsigned m_cnt;

  always #10 clk = ~clk;

  fsk_ramp_sweep dut_i (
    .clk(clk), .rst(rst), .lo_word(lo_word), .hi_word(hi_word),
    .step_mag(step_mag), .step_interval(step_interval),
    .dir_up(dir_up), .freeze(freeze), .tune_word(tune_word)
  );

  // behavioural reference
  always @(posedge clk) begin
    longint unsigned lo, hi, mg;
    lo = longint'(lo_word); hi = longint'(hi_word); mg = longint'(step_mag);
    if (rst) begin
      m_word <= lo;
      m_cnt  <= longint'(step_interval);
    end else if (!freeze) begin
      if (m_cnt == 0) begin
        m_cnt <= longint'(step_interval);
        if (dir_up) m_word <= (m_word + mg >= hi) ? hi : m_word + mg;
        else        m_word <= (m_word <= lo + mg) ? lo : m_word - mg;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (tune_word !== m_word[FW-1:0]) begin
        errors++;
        $display("FAIL %s: tune_word actual %0d expected %0d at %0t",
                 tag, tune_word, m_word[FW-1:0], $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic point_check(input string req, input longint unsigned exp);
    @(negedge clk);
    checks++;
    if (tune_word !== exp[FW-1:0]) begin
      errors++;
      $display("FAIL %s: tune_word actual %0d expected %0d", req, tune_word, exp[FW-1:0]);
    end
  endtask

  initial begin
    tag = "R1"; run(3);
    point_check("R1", 1000);
    rst = 1'b0; dir_up = 1'b1; tag = "R2_R3";
    run(12);
    point_check("R3", 1090);
    tag = "R5"; run(12);
    point_check("R5", 1100);
    tag = "R4"; dir_up = 1'b0; run(6);
    tag = "R7"; freeze = 1'b1; run(7);
    freeze = 1'b0; tag = "R7_R4"; run(5);
    tag = "R6"; run(16);
    point_check("R6", 1000);
    // endpoint on the step grid
    tag = "R5_grid"; rst = 1'b1; lo_word = 0; hi_word = 90; step_mag = 30; step_interval = 0;
    run(2); rst = 1'b0; dir_up = 1'b1; run(6);
    point_check("R5", 90);
    tag = "R6_grid"; dir_up = 1'b0; run(6);
    point_check("R6", 0);
    // longer interval, freeze mid-interval
    tag = "R2_long"; rst = 1'b1; lo_word = 500; hi_word = 900; step_mag = 7; step_interval = 9;
    run(2); rst = 1'b0; dir_up = 1'b1; run(15);
    tag = "R7_mid"; freeze = 1'b1; run(4); freeze = 1'b0; tag = "R2_long"; run(30);
    // top of range, no wrap
    tag = "R9_top"; rst = 1'b1; hi_word = 48'hFFFF_FFFF_FFFF; lo_word = 48'hFFFF_FFFF_FF00;
    step_mag = 48'h40; step_interval = 1;
    run(2); rst = 1'b0; dir_up = 1'b1; run(20);
    point_check("R9", 64'h0000_FFFF_FFFF_FFFF);
    tag = "R9_bottom"; rst = 1'b1; lo_word = 5; hi_word = 200; step_mag = 48'h50;
    run(2); rst = 1'b0; dir_up = 1'b1; run(12); dir_up = 1'b0; run(12);
    point_check("R9", 5);
    tag = "R8"; run(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    done = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule